// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of devices, picks the most urgent one that the CPU is currently willing to take, and raises a single request line to the CPU. Each device has its own priority. A request counts as eligible only when the global enable is set and its priority is strictly above the CPU's current level. Requests that are not eligible stay pending at the device and appear as soon as they become eligible. A non-maskable request line outranks every device and ignores both the enable and the level.

When the CPU accepts with its acknowledge, the controller freezes the winning device and routes an acknowledge to that device alone. It then waits for that device to return a handler vector. The vector goes to the CPU over a valid/ready output. The vector stays on the output until the CPU takes it, so the CPU can apply back-pressure by holding ready low. If the device returns no vector within a fixed number of cycles, the controller drops the device acknowledge and pulses a bus-error flag instead. A non-maskable request is answered with vector 0 and involves no device.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, cpu_irq, dev_ack, vec_valid and bus_err are all low.
- R2: A device request whose priority (unsigned, device i in dev_prio bits [i*PRIO_W +: PRIO_W]) is less than or equal to cur_level does not raise cpu_irq. Once cur_level falls below that priority, cpu_irq rises combinationally in the same cycle.
- R3: With glob_en low, no device request raises cpu_irq. nmi_req raises cpu_irq regardless of glob_en and cur_level.
- R4: Among eligible devices, the one with the highest priority wins. On equal priorities, the lower device index wins.
- R5: In the cycle after cpu_ack is sampled high while cpu_irq is high, dev_ack is one-hot on the winner (bit i for device i). It stays unchanged until a vector or a timeout ends the wait, even if requests, priorities or cur_level change.
- R6: When the winner's dev_vec_valid bit is high during the wait, its dev_vec slice (bits [i*VEC_W +: VEC_W]) is captured. In the next cycle vec_valid is high with that value on vec_out, and dev_ack is zero.
- R7: While vec_valid is high and vec_ready is low, vec_valid and vec_out hold. In the cycle after vec_ready is sampled high with vec_valid, vec_valid is low.
- R8: If nmi_req is high when the acknowledge is taken, it wins over every device. In the next cycle vec_valid is high with vec_out = 0, and dev_ack stays zero.
- R9: If the winner gives no vector for TIMEOUT_CYC cycles of dev_ack (16 by default), dev_ack drops and bus_err is high for exactly one cycle, with vec_valid low.
- R10: cpu_ack sampled while cpu_irq is low has no effect: dev_ack and vec_valid remain low.
- R11: dev_vec_valid from a device other than the frozen winner is ignored, and the wait continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_req | input | N_DEV | Per-device request lines |
| dev_prio | input | N_DEV*PRIO_W | Packed per-device priorities |
| cur_level | input | PRIO_W | CPU's current priority level |
| glob_en | input | 1 | Global enable for maskable requests |
| nmi_req | input | 1 | Non-maskable request |
| cpu_irq | output | 1 | Interrupt request to the CPU |
| cpu_ack | input | 1 | CPU acknowledge |
| dev_ack | output | N_DEV | Per-device acknowledge, one-hot |
| dev_vec_valid | input | N_DEV | Per-device vector valid |
| dev_vec | input | N_DEV*VEC_W | Packed per-device vectors |
| vec_out | output | VEC_W | Vector to the CPU |
| vec_valid | output | 1 | Vector valid |
| vec_ready | input | 1 | CPU ready to take the vector |
| bus_err | output | 1 | One-cycle pulse on vector timeout |

## Verification
cpu_irq is combinational, so the bench changes requests, levels and enables at a falling edge and reads cpu_irq shortly after, in the same cycle. dev_ack, vec_valid and bus_err are registered one edge after the event that causes them: an accepted acknowledge, a captured vector, or an expired wait. The bench therefore drives each event before a rising edge and checks the result at the next falling edge. For the timeout, the bench counts falling edges from the rise of dev_ack. It expects dev_ack to be held through the 16th edge and bus_err to appear only after it, for one cycle.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DLVR = 2'd2
  } ivc_state_e;
endpackage

// File: rtl/ivc_select.sv
module ivc_select #(
  parameter int N_DEV  = 4,
  parameter int PRIO_W = 3,
  localparam int IW    = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic [N_DEV-1:0]        req,
  input  logic [N_DEV*PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]       level,
  input  logic                    en,
  output logic                    any,
  output logic [IW-1:0]           idx
);
  logic [N_DEV-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < N_DEV; g++) begin : g_elig
      assign elig[g] = en && req[g] && (prio[g*PRIO_W +: PRIO_W] > level);
    end
  endgenerate

  logic [PRIO_W-1:0] best;
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < N_DEV; i++) begin
      // strict compare keeps the lower index on ties
      if (elig[i] && (!any || prio[i*PRIO_W +: PRIO_W] > best)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = prio[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/ivc_wdog.sv
module ivc_wdog #(
  parameter int TIMEOUT_CYC = 16,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end

  assign expire = run && (cnt == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int N_DEV       = 4,
  parameter int PRIO_W      = 3,
  parameter int VEC_W       = 8,
  parameter int TIMEOUT_CYC = 16,
  localparam int IW         = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_DEV-1:0]        dev_req,
  input  logic [N_DEV*PRIO_W-1:0] dev_prio,
  input  logic [PRIO_W-1:0]       cur_level,
  input  logic                    glob_en,
  input  logic                    nmi_req,
  output logic                    cpu_irq,
  input  logic                    cpu_ack,
  output logic [N_DEV-1:0]        dev_ack,
  input  logic [N_DEV-1:0]        dev_vec_valid,
  input  logic [N_DEV*VEC_W-1:0]  dev_vec,
  output logic [VEC_W-1:0]        vec_out,
  output logic                    vec_valid,
  input  logic                    vec_ready,
  output logic                    bus_err
);
  ivc_state_e        state;
  logic [IW-1:0]     win_q;
  logic [VEC_W-1:0]  vec_q;
  logic              err_q;
  logic              sel_any;
  logic [IW-1:0]     sel_idx;
  logic              tmo;
  logic              win_vld;
  logic [VEC_W-1:0]  win_vec;

  ivc_select #(.N_DEV(N_DEV), .PRIO_W(PRIO_W)) u_sel (
    .req   (dev_req),
    .prio  (dev_prio),
    .level (cur_level),
    .en    (glob_en),
    .any   (sel_any),
    .idx   (sel_idx)
  );

  ivc_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == ST_WAIT),
    .expire (tmo)
  );

  assign win_vld = dev_vec_valid[win_q];
  assign win_vec = dev_vec[win_q*VEC_W +: VEC_W];

  assign cpu_irq = (state == ST_IDLE) && (nmi_req || sel_any);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      win_q <= '0;
      vec_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cpu_irq && cpu_ack) begin
            if (nmi_req) begin
              vec_q <= '0;
              state <= ST_DLVR;
            end else begin
              win_q <= sel_idx;
              state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (win_vld) begin
            vec_q <= win_vec;
            state <= ST_DLVR;
          end else if (tmo) begin
            err_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_DLVR: begin
          if (vec_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < N_DEV; g++) begin : g_ack
      assign dev_ack[g] = (state == ST_WAIT) && (win_q == IW'(g));
    end
  endgenerate

  assign vec_valid = (state == ST_DLVR);
  assign vec_out   = vec_q;
  assign bus_err   = err_q;
endmodule

// File: rtl/ivc_checker.sv
module ivc_checker #(
  parameter int N_DEV = 4,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_irq,
  input logic             cpu_ack,
  input logic [N_DEV-1:0] dev_ack,
  input logic [VEC_W-1:0] vec_out,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic             bus_err
);
  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_ack));

  // R5
  ack_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack != '0) |=> (dev_ack == '0 || $stable(dev_ack)));

  // R7
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_out)));

  // R9
  err_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (!vec_valid && dev_ack == '0));

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !bus_err);

  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && !cpu_irq && dev_ack == '0 && !vec_valid) |=> (dev_ack == '0 && !vec_valid));

  // R2
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (dev_ack == '0 && !vec_valid));
endmodule

bind irq_vec_ctrl ivc_checker #(.N_DEV(N_DEV), .VEC_W(VEC_W)) u_ivc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_irq   (cpu_irq),
  .cpu_ack   (cpu_ack),
  .dev_ack   (dev_ack),
  .vec_out   (vec_out),
  .vec_valid (vec_valid),
  .vec_ready (vec_ready),
  .bus_err   (bus_err)
);

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
  localparam int N  = 4;
  localparam int PW = 3;
  localparam int VW = 8;
  localparam int TO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic [N*PW-1:0] dev_prio = '0;
  logic [PW-1:0] cur_level = '0;
  logic          glob_en = 1'b0;
  logic          nmi_req = 1'b0;
  logic          cpu_irq;
  logic          cpu_ack = 1'b0;
  logic [N-1:0]  dev_ack;
  logic [N-1:0]  dev_vec_valid = '0;
  logic [N*VW-1:0] dev_vec = '0;
  logic [VW-1:0] vec_out;
  logic          vec_valid;
  logic          vec_ready = 1'b0;
  logic          bus_err;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_vec_ctrl #(.N_DEV(N), .PRIO_W(PW), .VEC_W(VW), .TIMEOUT_CYC(TO)) u_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_prio(dev_prio),
    .cur_level(cur_level), .glob_en(glob_en), .nmi_req(nmi_req),
    .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .dev_ack(dev_ack),
    .dev_vec_valid(dev_vec_valid), .dev_vec(dev_vec), .vec_out(vec_out),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .bus_err(bus_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    dev_req = '0; dev_prio = '0; cur_level = '0; glob_en = 1'b0;
    nmi_req = 1'b0; cpu_ack = 1'b0; dev_vec_valid = '0; dev_vec = '0;
    vec_ready = 1'b0;
    tick();
  endtask

  // take the acknowledge: one edge with cpu_ack high
  task automatic do_ack();
    @(negedge clk); cpu_ack = 1'b1;
    @(negedge clk); cpu_ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 cpu_irq", 32'(cpu_irq), 0);
    chk("R1 dev_ack", 32'(dev_ack), 0);
    chk("R1 vec_valid", 32'(vec_valid), 0);
    chk("R1 bus_err", 32'(bus_err), 0);
  endtask

  task automatic t_mask();
    @(negedge clk);
    glob_en = 1'b1; dev_req = 4'b0001; dev_prio[0 +: PW] = 3'd2; cur_level = 3'd2;
    #1 chk("R2 equal level masked", 32'(cpu_irq), 0);
    cur_level = 3'd3;
    #1 chk("R2 higher level masked", 32'(cpu_irq), 0);
    cur_level = 3'd1;
    #1 chk("R2 level dropped", 32'(cpu_irq), 1);
    cur_level = 3'd2;
    #1;
    do_ack();
    chk("R10 stray ack dev_ack", 32'(dev_ack), 0);
    chk("R10 stray ack vec_valid", 32'(vec_valid), 0);
    idle_inputs();
  endtask

  task automatic t_global();
    @(negedge clk);
    glob_en = 1'b0; dev_req = 4'b1000; dev_prio[3*PW +: PW] = 3'd7; cur_level = 3'd0;
    #1 chk("R3 enable masks", 32'(cpu_irq), 0);
    nmi_req = 1'b1; cur_level = 3'd7;
    #1 chk("R3 nmi unmasked", 32'(cpu_irq), 1);
    idle_inputs();
  endtask

  task automatic t_select();
    @(negedge clk);
    glob_en = 1'b1; dev_req = 4'b1110;
    dev_prio[1*PW +: PW] = 3'd3; dev_prio[2*PW +: PW] = 3'd5; dev_prio[3*PW +: PW] = 3'd5;
    dev_vec[2*VW +: VW] = 8'hA5; dev_vec[3*VW +: VW] = 8'h3C;
    #1;
    do_ack();
    chk("R4 tie to lower index", 32'(dev_ack), 32'h4);
    chk("R5 irq low while busy", 32'(cpu_irq), 0);
    @(negedge clk);
    cur_level = 3'd7; dev_req = 4'b1000; dev_vec_valid = 4'b1000;
    tick();
    chk("R11 other vector ignored", 32'(vec_valid), 0);
    chk("R5 winner frozen", 32'(dev_ack), 32'h4);
    @(negedge clk);
    dev_vec_valid = 4'b0100;
    tick();
    dev_vec_valid = '0;
    chk("R6 vec_valid", 32'(vec_valid), 1);
    chk("R6 vec_out", 32'(vec_out), 32'hA5);
    chk("R6 dev_ack cleared", 32'(dev_ack), 0);
    tick();
    chk("R7 held valid", 32'(vec_valid), 1);
    chk("R7 held data", 32'(vec_out), 32'hA5);
    @(negedge clk); vec_ready = 1'b1;
    tick(); vec_ready = 1'b0;
    chk("R7 released", 32'(vec_valid), 0);
    idle_inputs();
  endtask

  task automatic t_nmi();
    @(negedge clk);
    glob_en = 1'b1; dev_req = 4'b0001; dev_prio[0 +: PW] = 3'd7; nmi_req = 1'b1;
    #1;
    do_ack();
    chk("R8 nmi vec_valid", 32'(vec_valid), 1);
    chk("R8 nmi vector 0", 32'(vec_out), 0);
    chk("R8 no dev_ack", 32'(dev_ack), 0);
    @(negedge clk); vec_ready = 1'b1; nmi_req = 1'b0;
    idle_inputs();
  endtask

  task automatic t_timeout();
    int held = 0;
    @(negedge clk);
    glob_en = 1'b1; dev_req = 4'b0010; dev_prio[1*PW +: PW] = 3'd4;
    #1;
    do_ack();
    chk("R9 ack up", 32'(dev_ack), 32'h2);
    for (int k = 1; k < TO; k++) begin
      tick();
      if (dev_ack == 4'b0010 && !bus_err) held++;
    end
    chk("R9 ack held full window", 32'(held), 32'(TO - 1));
    tick();
    chk("R9 bus_err", 32'(bus_err), 1);
    chk("R9 ack dropped", 32'(dev_ack), 0);
    chk("R9 no vector", 32'(vec_valid), 0);
    dev_req = '0;
    tick();
    chk("R9 one-cycle pulse", 32'(bus_err), 0);
    idle_inputs();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    tick();
    t_mask();
    t_global();
    t_select();
    t_nmi();
    t_timeout();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule